// File: doc/BRIEF.md
# Tagged-Fetch Control-Flow Signature Checker

This block sits on the instruction fetch path between a memory and a processor. Each memory word arrives with a 2-bit tag that marks it as an ordinary instruction, an embedded reference signature, or a reserved code. While the program runs through a branch-free stretch of code, the checker adds every fetched instruction word into a running checksum. When a signature-tagged word arrives, the checker compares that word with the checksum and then clears the checksum so the next stretch starts from zero.

The processor never executes a signature word. While one is on the bus, the checker shows the processor a no-operation encoding in its place. Instruction words pass through to the processor with no added delay. A disagreement between the checksum and the reference, or a fetch that carries a reserved tag, sets an error flag. The flag stays set until the controlling logic pulses a clear input.

Top module: `cf_sig_watchdog`

## Requirements
- R1: After reset the error flag is 0 and the checksum is 0, so a signature word of 0 fetched first raises no error.
- R2: When a fetch is valid and its tag is 2'b00 (instruction), `cpu_word` equals `mem_word` in the same cycle.
- R3: When a fetch is valid and its tag is 2'b01 (signature), `cpu_word` is the NOP encoding (parameter `NOP_WORD`, default 16'h0000) in the same cycle.
- R4: Each valid fetch tagged 2'b00 adds the low `SIG_W` bits of its word into the checksum, modulo 2^SIG_W. Words tagged otherwise are not added.
- R5: A valid fetch tagged 2'b01 whose low `SIG_W` bits differ from the checksum sets `sig_error` at the next clock edge. A matching one leaves the flag unchanged.
- R6: After every valid signature fetch, whether it matches or not, the checksum returns to 0.
- R7: A valid fetch tagged 2'b10 or 2'b11 sets `sig_error` at the next edge and leaves the checksum unchanged.
- R8: `sig_error` stays set until `err_clr` is high at a clock edge. If a new error is detected at the same edge as the clear, the flag stays set.
- R9: When `fetch_valid` is low, neither the checksum nor the error flag changes, whatever the tag and word are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_valid | input | 1 | A fetch is on the memory bus this cycle |
| mem_tag | input | 2 | Tag of the fetched word: 00 instruction, 01 signature, 10/11 reserved |
| mem_word | input | DATA_W | Fetched word from memory |
| err_clr | input | 1 | Clears the error flag |
| cpu_word | output | DATA_W | Word presented to the processor |
| sig_error | output | 1 | Sticky control-flow error flag |

## Verification
The bench sweeps intervals of lengths 0 to 20 with arithmetic word patterns that wrap the 16-bit sum. Each interval ends with its correct signature and then with references that differ in each single bit. A design that kept carries beyond 16 bits, or that did not clear the checksum after a compare, would report false errors on later intervals. The bench mixes in idle cycles, including signature-tagged words with the valid qualifier low, and reserved tags. A design that accumulated idle or reserved words would then fail the next correct signature. It also drives a clear in the same cycle as a mismatch, and a design that let the clear win would lose that error.

// File: rtl/cf_sig_watchdog.sv
module cf_sig_watchdog #(
  parameter int DATA_W = 16,
  parameter int SIG_W = 16,
  parameter logic [DATA_W-1:0] NOP_WORD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [1:0]        mem_tag,
  input  logic [DATA_W-1:0] mem_word,
  input  logic              err_clr,
  output logic [DATA_W-1:0] cpu_word,
  output logic              sig_error
);
  localparam logic [1:0] TAG_INSN = 2'b00;
  localparam logic [1:0] TAG_SIG  = 2'b01;

  logic [SIG_W-1:0] acc;
  logic [SIG_W-1:0] word_low;
  logic is_insn, is_sig, is_rsvd, mismatch;

  assign word_low = mem_word[SIG_W-1:0];
  assign is_insn  = fetch_valid && (mem_tag == TAG_INSN);
  assign is_sig   = fetch_valid && (mem_tag == TAG_SIG);
  assign is_rsvd  = fetch_valid && mem_tag[1];
  assign mismatch = is_sig && (word_low != acc);

  assign cpu_word = is_sig ? NOP_WORD : mem_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc <= '0;
    else if (is_sig)  acc <= '0;
    else if (is_insn) acc <= acc + word_low;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      sig_error <= 1'b0;
    else if (mismatch || is_rsvd)    sig_error <= 1'b1;
    else if (err_clr)                sig_error <= 1'b0;
  end

  a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && mem_tag == 2'b00 |-> cpu_word == mem_word);

  a_r3_nop_on_sig: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && mem_tag == 2'b01 |-> cpu_word == NOP_WORD);

  a_r6_acc_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && mem_tag == 2'b01 |=> acc == '0);

  a_r7_reserved_err: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && mem_tag[1] |=> sig_error);

  a_r7_reserved_acc: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && mem_tag[1] |=> $stable(acc));

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    sig_error && !err_clr |=> sig_error);

  a_r9_idle_acc: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |=> $stable(acc));

  a_r9_idle_err: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid && !err_clr |=> $stable(sig_error));
endmodule

// File: tb/cf_sig_watchdog_tb.sv
module cf_sig_watchdog_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_valid = 1'b0;
  logic [1:0] mem_tag = 2'b00;
  logic [15:0] mem_word = '0;
  logic err_clr = 1'b0;
  logic [15:0] cpu_word;
  logic sig_error;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] m_acc = '0;
  logic m_err = 1'b0;

  always #2.5 clk = ~clk;

  cf_sig_watchdog u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .mem_tag(mem_tag),
    .mem_word(mem_word), .err_clr(err_clr), .cpu_word(cpu_word), .sig_error(sig_error)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [1:0] t, input logic [15:0] w,
                      input logic clr, input string req);
    @(negedge clk);
    fetch_valid = v; mem_tag = t; mem_word = w; err_clr = clr;
    #1;
    if (v && t == 2'b00) chk("R2 pass-through", cpu_word, w);
    if (v && t == 2'b01) chk("R3 nop substitution", cpu_word, 16'h0000);
    if (clr) m_err = 1'b0;
    if (v && (t[1] || (t == 2'b01 && w != m_acc))) m_err = 1'b1;
    if (v && t == 2'b01) m_acc = '0;
    else if (v && t == 2'b00) m_acc = m_acc + w;
    @(posedge clk);
    #1;
    chk(req, {15'b0, sig_error}, {15'b0, m_err});
  endtask

  task automatic run_interval(input int len, input int seed, input logic [15:0] flip,
                              input string req);
    for (int i = 0; i < len; i++) begin
      step(1'b1, 2'b00, 16'(seed * 4099 + i * 40503), 1'b0, "R4 accumulate");
      if (i % 3 == 1) step(1'b0, 2'b01, 16'(i * 777), 1'b0, "R9 idle sig word ignored");
      if (i % 5 == 2) step(1'b0, 2'b00, 16'hBEEF, 1'b0, "R9 idle insn ignored");
    end
    step(1'b1, 2'b01, m_acc ^ flip, 1'b0, req);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #12;
    chk("R1 reset error flag", {15'b0, sig_error}, 16'h0);
    @(negedge clk); rst_n = 1'b1;
    step(1'b1, 2'b01, 16'h0000, 1'b0, "R1 zero checksum after reset");

    for (int len = 0; len <= 20; len++)
      run_interval(len, len + 3, 16'h0000, "R5 match leaves flag clear");

    step(1'b1, 2'b00, 16'hFFFF, 1'b0, "R4 wrap");
    step(1'b1, 2'b00, 16'h0002, 1'b0, "R4 wrap");
    chk("R4 modular sum", m_acc, 16'h0001);
    step(1'b1, 2'b01, 16'h0001, 1'b0, "R4 wrapped sum matches");

    for (int b = 0; b < 16; b++) begin
      run_interval(b % 7 + 1, b, 16'(1 << b), "R5 single-bit mismatch sets flag");
      step(1'b1, 2'b00, 16'h1234, 1'b0, "R8 flag sticky");
      step(1'b0, 2'b00, 16'h0, 1'b0, "R8 flag sticky idle");
      step(1'b0, 2'b00, 16'h0, 1'b1, "R8 clear");
      step(1'b1, 2'b01, 16'h1234, 1'b0, "R6 checksum restarted after mismatch");
    end

    step(1'b1, 2'b00, 16'h0100, 1'b0, "R4 accumulate");
    step(1'b1, 2'b10, 16'h5555, 1'b0, "R7 tag 10 sets flag");
    step(1'b0, 2'b00, 16'h0, 1'b1, "R8 clear");
    step(1'b1, 2'b11, 16'hAAAA, 1'b0, "R7 tag 11 sets flag");
    step(1'b0, 2'b00, 16'h0, 1'b1, "R8 clear");
    step(1'b1, 2'b01, 16'h0100, 1'b0, "R7 reserved words not accumulated");

    step(1'b1, 2'b00, 16'h0042, 1'b0, "R4 accumulate");
    step(1'b1, 2'b01, 16'h0043, 1'b1, "R8 set wins over clear");
    step(1'b1, 2'b10, 16'h0, 1'b1, "R8 reserved wins over clear");
    step(1'b0, 2'b00, 16'h0, 1'b1, "R8 clear");
    step(1'b1, 2'b01, 16'h0000, 1'b0, "R6 checksum zero after compare");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule